// File: doc/BRIEF.md
# User Decrementer Timer

This block is a signed down-counter driven by a time base. Each cycle in which the single-cycle tick strobe is high, the counter drops by one. A tick that moves the counter from one to zero latches an exception status bit, and the counter then parks at zero until software loads a new value. The counter is treated as a signed integer, so negative values keep counting down and do not stop.

Software reaches the block through a counter read and write port and through two single-bit controls: an interrupt enable and a write-one-to-clear status bit. An external access-enable level decides whether counter reads and writes are accepted. A rejected access leaves the counter untouched, reads back as zero and raises a one-cycle illegal-access flag. The interrupt request is held high for as long as both the status bit and the enable bit are set.

Top module: `udec_timer`

## Requirements
- R1: After reset the counter holds the largest positive value (0x7FFFFFFF at the default width of 32), and status, enable, interrupt and illegal flag are all 0.
- R2: On a cycle with `tick_i` high and no accepted counter write, a nonzero counter (positive or negative) becomes one less on the next cycle.
- R3: A tick with the counter at 1 sets the status bit on the next cycle, whether the interrupt enable is 0 or 1.
- R4: An accepted counter write loads `cnt_wdata_i` on the next cycle, and a write of zero does not set the status bit.
- R5: When an accepted write and a tick with the counter at 1 fall in the same cycle, the status bit is set and the counter takes the written value, not 0.
- R6: With the counter at 0 a tick leaves it at 0 and raises no further status.
- R7: A status write with `sts_wdata_i` = 1 clears the status bit on the next cycle; with `sts_wdata_i` = 0 it has no effect; a 1-to-0 tick in the same cycle as a clear leaves the status bit at 1.
- R8: `irq_o` is high exactly while both the status bit and the enable bit (written through `ien_wr_i`/`ien_wdata_i`) are 1, and stays high until one of them is cleared.
- R9: With `acc_en_i` at 0, a counter write is ignored, a counter read returns 0, and `illegal_o` is high for exactly the one cycle after each such access.
- R10: An accepted read (`cnt_rd_i` and `acc_en_i` both 1) shows the current counter value on `cnt_rdata_o` in the same cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time base tick strobe, one cycle wide |
| acc_en_i | input | 1 | Counter access allowed when 1 |
| cnt_wr_i | input | 1 | Counter write request |
| cnt_rd_i | input | 1 | Counter read request |
| cnt_wdata_i | input | CNT_W | Value to load into the counter |
| cnt_rdata_o | output | CNT_W | Counter value on an accepted read, else 0 |
| sts_wr_i | input | 1 | Status bit write strobe |
| sts_wdata_i | input | 1 | 1 clears the status bit, 0 does nothing |
| ien_wr_i | input | 1 | Interrupt enable write strobe |
| ien_wdata_i | input | 1 | New interrupt enable value |
| sts_o | output | 1 | Latched exception status |
| ien_o | output | 1 | Interrupt enable bit |
| irq_o | output | 1 | Interrupt request, level |
| illegal_o | output | 1 | One-cycle flag after a rejected counter access |

## Verification
The bench aims at the cycle where a tick meets a counter of 1 while software writes the counter or clears the status: a design with the priorities reversed would drop the status, load zero instead of the written value, or let the clear win. It writes zero to both a running and a stopped counter, where a design that tests for zero instead of the 1-to-0 step would raise a false exception, and it ticks a stopped counter, which a design without the hold would wrap to all ones. Rejected accesses check that the counter is left alone, that the read data is zero and that the flag is one cycle wide rather than sticky, and a random phase with small load values reaches these meetings many times over.

// File: rtl/udt_pkg.sv
package udt_pkg;

   // Decoded software request to the counter after the access check.
   typedef struct packed {
      logic wr;
      logic rd;
   } udt_acc_t;

   // Largest positive signed value for a given width.
   function automatic logic [63:0] udt_max_pos(input int unsigned w);
      logic [63:0] v;
      v = '0;
      for (int unsigned i = 0; i + 1 < w; i++) v[i] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/udt_access_guard.sv
module udt_access_guard #(
   parameter bit ILL_REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_en_i,
   input  logic               wr_i,
   input  logic               rd_i,
   output udt_pkg::udt_acc_t  ok_o,
   output logic               illegal_o
);

   logic rejected;

   assign ok_o.wr  = wr_i & acc_en_i;
   assign ok_o.rd  = rd_i & acc_en_i;
   assign rejected = (wr_i | rd_i) & ~acc_en_i;

   generate
      if (ILL_REGISTERED) begin : g_ill_reg
         logic ill_q;
         always_ff @(posedge clk) begin
            if (!rst_n) ill_q <= 1'b0;
            else        ill_q <= rejected;
         end
         assign illegal_o = ill_q;
      end else begin : g_ill_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign illegal_o  = rejected;
      end
   endgenerate

endmodule

// File: rtl/udt_count_core.sv
module udt_count_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o
);

   localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(udt_pkg::udt_max_pos(CNT_W));
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             running;

   assign running = (cnt_q != '0);
   assign hit_o   = tick_i & (cnt_q == ONE);

   always_comb begin
      cnt_d = cnt_q;
      if (load_i)                 cnt_d = load_val_i;
      else if (tick_i && running) cnt_d = cnt_q - ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= RST_VAL;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/udt_status_latch.sv
module udt_status_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_wr_i,
   input  logic clr_data_i,
   input  logic ien_wr_i,
   input  logic ien_data_i,
   output logic sts_o,
   output logic ien_o,
   output logic irq_o
);

   logic sts_q;
   logic ien_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q <= 1'b0;
         ien_q <= 1'b0;
      end else begin
         if (set_i)                       sts_q <= 1'b1;
         else if (clr_wr_i && clr_data_i) sts_q <= 1'b0;
         if (ien_wr_i) ien_q <= ien_data_i;
      end
   end

   assign sts_o = sts_q;
   assign ien_o = ien_q;
   assign irq_o = sts_q & ien_q;

endmodule

// File: rtl/udec_timer.sv
module udec_timer #(
   parameter int unsigned CNT_W          = 32,
   parameter bit          ILL_REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             acc_en_i,
   input  logic             cnt_wr_i,
   input  logic             cnt_rd_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   output logic [CNT_W-1:0] cnt_rdata_o,
   input  logic             sts_wr_i,
   input  logic             sts_wdata_i,
   input  logic             ien_wr_i,
   input  logic             ien_wdata_i,
   output logic             sts_o,
   output logic             ien_o,
   output logic             irq_o,
   output logic             illegal_o
);

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 64)
         else $fatal(1, "udec_timer: CNT_W must lie in 2..64");
   end

   udt_pkg::udt_acc_t acc_ok;
   logic [CNT_W-1:0]  cnt_q;
   logic              hit;

   udt_access_guard #(
      .ILL_REGISTERED(ILL_REGISTERED)
   ) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_en_i  (acc_en_i),
      .wr_i      (cnt_wr_i),
      .rd_i      (cnt_rd_i),
      .ok_o      (acc_ok),
      .illegal_o (illegal_o)
   );

   udt_count_core #(
      .CNT_W(CNT_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .load_i     (acc_ok.wr),
      .load_val_i (cnt_wdata_i),
      .cnt_o      (cnt_q),
      .hit_o      (hit)
   );

   udt_status_latch u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (hit),
      .clr_wr_i   (sts_wr_i),
      .clr_data_i (sts_wdata_i),
      .ien_wr_i   (ien_wr_i),
      .ien_data_i (ien_wdata_i),
      .sts_o      (sts_o),
      .ien_o      (ien_o),
      .irq_o      (irq_o)
   );

   assign cnt_rdata_o = acc_ok.rd ? cnt_q : '0;

endmodule

// File: rtl/udec_timer_chk.sv
module udec_timer_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             acc_en_i,
   input logic             cnt_wr_i,
   input logic             cnt_rd_i,
   input logic [CNT_W-1:0] cnt_wdata_i,
   input logic             sts_wr_i,
   input logic             sts_wdata_i,
   input logic             sts_o,
   input logic             ien_o,
   input logic             irq_o,
   input logic             illegal_o,
   input logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   p_tick_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && cnt_q != '0 && !(cnt_wr_i && acc_en_i)) |=> (cnt_q == $past(cnt_q) - ONE));

   p_hit_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && cnt_q == ONE) |=> sts_o);

   p_write_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr_i && acc_en_i) |=> (cnt_q == $past(cnt_wdata_i)));

   p_quiet_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_o && cnt_wr_i && acc_en_i && !(tick_i && cnt_q == ONE)) |=> !sts_o);

   p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !(cnt_wr_i && acc_en_i)) |=> (cnt_q == '0));

   p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr_i && sts_wdata_i && !(tick_i && cnt_q == ONE)) |=> !sts_o);

   p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien_o || !sts_o) |-> !irq_o);

   p_ill_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_wr_i || cnt_rd_i) && !acc_en_i) |=> illegal_o);

   p_ill_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !((cnt_wr_i || cnt_rd_i) && !acc_en_i) |=> !illegal_o);

   p_reject_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr_i && !acc_en_i && !tick_i) |=> $stable(cnt_q));

endmodule

bind udec_timer udec_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .acc_en_i    (acc_en_i),
   .cnt_wr_i    (cnt_wr_i),
   .cnt_rd_i    (cnt_rd_i),
   .cnt_wdata_i (cnt_wdata_i),
   .sts_wr_i    (sts_wr_i),
   .sts_wdata_i (sts_wdata_i),
   .sts_o       (sts_o),
   .ien_o       (ien_o),
   .irq_o       (irq_o),
   .illegal_o   (illegal_o),
   .cnt_q       (cnt_q)
);

// File: tb/test_udec_timer.sv
`timescale 1ns/1ps
module test_udec_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0, acc_en_i = 1'b1, cnt_wr_i = 1'b0, cnt_rd_i = 1'b0;
   logic [31:0] cnt_wdata_i = '0;
   logic [31:0] cnt_rdata_o;
   logic        sts_wr_i = 1'b0, sts_wdata_i = 1'b0, ien_wr_i = 1'b0, ien_wdata_i = 1'b0;
   logic        sts_o, ien_o, irq_o, illegal_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   udec_timer i_udec_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .acc_en_i(acc_en_i),
      .cnt_wr_i(cnt_wr_i), .cnt_rd_i(cnt_rd_i), .cnt_wdata_i(cnt_wdata_i),
      .cnt_rdata_o(cnt_rdata_o), .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i),
      .ien_wr_i(ien_wr_i), .ien_wdata_i(ien_wdata_i), .sts_o(sts_o),
      .ien_o(ien_o), .irq_o(irq_o), .illegal_o(illegal_o)
   );

   // Behavioural reference state
   int unsigned m_cnt;
   bit          m_sts, m_ien, m_ill;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= 32'h7FFF_FFFF;
         m_sts <= 1'b0;
         m_ien <= 1'b0;
         m_ill <= 1'b0;
      end else begin
         if (cnt_wr_i && acc_en_i)        m_cnt <= cnt_wdata_i;
         else if (tick_i && m_cnt != 0)   m_cnt <= m_cnt - 1;
         if (tick_i && m_cnt == 1)          m_sts <= 1'b1;
         else if (sts_wr_i && sts_wdata_i)  m_sts <= 1'b0;
         if (ien_wr_i) m_ien <= ien_wdata_i;
         m_ill <= (cnt_wr_i || cnt_rd_i) && !acc_en_i;
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // One cycle: check registered outputs, drive new inputs, check read data.
   task automatic step(input string tag, input bit tk, input bit acc, input bit wr,
                       input bit rd, input logic [31:0] wd, input bit sw, input bit sd,
                       input bit iw, input bit id);
      @(negedge clk);
      chk(tag, "sts_o",     {31'b0, sts_o},     {31'b0, m_sts});
      chk(tag, "ien_o",     {31'b0, ien_o},     {31'b0, m_ien});
      chk(tag, "irq_o",     {31'b0, irq_o},     {31'b0, m_sts & m_ien});
      chk(tag, "illegal_o", {31'b0, illegal_o}, {31'b0, m_ill});
      tick_i = tk; acc_en_i = acc; cnt_wr_i = wr; cnt_rd_i = rd; cnt_wdata_i = wd;
      sts_wr_i = sw; sts_wdata_i = sd; ien_wr_i = iw; ien_wdata_i = id;
      #1;
      chk(tag, "cnt_rdata_o", cnt_rdata_o, (rd && acc) ? m_cnt : 32'h0);
   endtask

   task automatic tk(input string tag);  step(tag, 1, 1, 0, 1, 0, 0, 0, 0, 0); endtask
   task automatic idle(input string tag); step(tag, 0, 1, 0, 1, 0, 0, 0, 0, 0); endtask
   task automatic wr(input string tag, input logic [31:0] v);
      step(tag, 0, 1, 1, 1, v, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset values, counter read back as 0x7FFFFFFF
      idle("R1");
      chk("R1", "reset count", cnt_rdata_o, 32'h7FFF_FFFF);
      // R2: ticks from reset value and from a negative value
      tk("R2"); tk("R2"); idle("R2");
      wr("R2", 32'hFFFF_FFFD); tk("R2"); tk("R2"); idle("R2");
      // R3: count to zero with enable off, status latches, irq stays low
      wr("R3", 32'd3); tk("R3"); tk("R3"); tk("R3"); idle("R3"); idle("R3");
      // R6: stopped counter ignores ticks
      tk("R6"); tk("R6"); tk("R6"); idle("R6");
      // R7: writing 0 to status has no effect, writing 1 clears
      step("R7", 0, 1, 0, 1, 0, 1, 0, 0, 0); idle("R7");
      step("R7", 0, 1, 0, 1, 0, 1, 1, 0, 0); idle("R7");
      // R4: zero written to a running and a stopped counter, no status
      wr("R4", 32'd5); tk("R4"); wr("R4", 32'd0); idle("R4"); wr("R4", 32'd0); idle("R4");
      // R5: write lands in the same cycle as the 1-to-0 tick
      wr("R5", 32'd1); step("R5", 1, 1, 1, 1, 32'h55, 0, 0, 0, 0); idle("R5"); idle("R5");
      step("R5", 0, 1, 0, 1, 0, 1, 1, 0, 0);
      // R7: clear coinciding with a new 1-to-0 tick, set wins
      wr("R7", 32'd1); step("R7", 1, 1, 0, 1, 0, 1, 1, 0, 0); idle("R7"); idle("R7");
      // R8: enable raises irq on a latched status, level until cleared
      step("R8", 0, 1, 0, 1, 0, 0, 0, 1, 1); idle("R8"); idle("R8");
      step("R8", 0, 1, 0, 1, 0, 1, 1, 0, 0); idle("R8");
      wr("R8", 32'd2); tk("R8"); tk("R8"); idle("R8");
      step("R8", 0, 1, 0, 1, 0, 0, 0, 1, 0); idle("R8");
      // R9: rejected write and read, flag one cycle wide
      wr("R9", 32'd40);
      step("R9", 0, 0, 1, 0, 32'd9, 0, 0, 0, 0); idle("R9"); idle("R9");
      step("R9", 0, 0, 0, 1, 0, 0, 0, 0, 0); idle("R9");
      step("R9", 1, 0, 1, 1, 32'd7, 0, 0, 0, 0); idle("R9"); idle("R9");
      // R10: repeated reads change nothing
      idle("R10"); idle("R10"); idle("R10");
      // R2: random mix with small load values
      for (int i = 0; i < 400; i++) begin
         step("R2", $urandom_range(0, 2) != 0, $urandom_range(0, 9) != 0,
              $urandom_range(0, 5) == 0, $urandom_range(0, 1) == 1,
              32'($urandom_range(0, 4)), $urandom_range(0, 7) == 0,
              $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0,
              $urandom_range(0, 1) == 1);
      end
      idle("R2");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule